// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block sits beside the load/store path and inspects every data access. It first applies process-ID relocation: an address whose top seven bits are all zero takes those bits from the current process-ID field, provided that field is nonzero. The relocated address is returned combinationally so that the memory path can use it. The block then checks the relocated address for word alignment when alignment checking is enabled. When debug is enabled, it also compares the address against two watch registers.

Each watch comparator has a 2-bit mode field that chooses which accesses it reacts to: none, stores only, any access, or loads only. A separate mask-mode bit changes how the registers are used. In that mode the second register becomes an inverse address mask for the first register, and the second comparator is no longer used. The block reports a hit as a single registered pulse, together with an entry-reason code and its write strobe. It reports a misaligned access as a separate registered abort pulse.

Top module: `data_watch_unit`

## Requirements
- R1: When `pid_hi` is nonzero and `acc_addr[31:25]` is zero, `eff_addr` equals `{pid_hi, acc_addr[24:0]}`. In every other case `eff_addr` equals `acc_addr`. All later checks use `eff_addr`.
- R2: `align_abort` pulses one cycle after a valid access when `align_chk_en` is 1 and `eff_addr[1:0]` is not 0. It does not pulse otherwise.
- R3: `bp_hit` never pulses when `dbg_en` was 0 at the access.
- R4: In `wp_ctrl`, bits 1:0 select the mode of comparator 0, bits 3:2 select the mode of comparator 1, and bit 8 is the mask-mode bit.
- R5: Mode encoding: 0 means the comparator is off, 1 matches stores only, 2 matches loads and stores, and 3 matches loads only. `acc_store` is 1 for a store and 0 for a load.
- R6: With mask mode set, comparator 0 hits when `(eff_addr & ~wp_addr1) == (wp_addr0 & ~wp_addr1)`, and comparator 1 never hits.
- R7: With mask mode clear, comparator i hits when `eff_addr[31:2]` equals the register's bits 31:2. Address bits 1:0 are ignored.
- R8: On a hit, `entry_code_we` pulses together with `bp_hit`, and `entry_code` equals 2.
- R9: After reset all outputs are 0. `bp_hit` and `align_abort` change only in the cycle after an access strobe and last exactly one cycle. A cycle with no strobe produces no pulse.
- R10: When both comparators hit on the same access, exactly one single-cycle `bp_hit` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address |
| pid_hi | input | 7 | Process-ID relocation bits |
| wp_ctrl | input | 9 | Watch control word |
| wp_addr0 | input | 32 | Watch register 0 |
| wp_addr1 | input | 32 | Watch register 1 or inverse mask |
| align_chk_en | input | 1 | Alignment check enable |
| dbg_en | input | 1 | Global debug enable |
| eff_addr | output | 32 | Relocated address |
| align_abort | output | 1 | Alignment abort pulse |
| bp_hit | output | 1 | Watchpoint hit pulse |
| entry_code | output | 3 | Debug entry reason |
| entry_code_we | output | 1 | Entry reason write strobe |

## Verification
The embedded assertions check several relations on every cycle:
- every hit or abort pulse traces back to an access strobe in the previous cycle;
- no hit follows a cycle with debug disabled or with every active mode field at zero;
- an abort always follows an enabled, misaligned address;
- the reason code is 2 whenever its strobe is high;
- the low address bits pass through relocation unchanged.

Only the directed scenarios can show the finer behaviour: the exact per-mode load/store selectivity, the masked comparison with the second comparator silenced, the boundary of the relocation condition, and the merging of a double hit into one pulse.

// File: rtl/data_watch_unit.sv
module data_watch_unit #(
  parameter int AW    = 32,
  parameter int PID_W = 7,
  parameter int GRAN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_store,
  input  logic [AW-1:0] acc_addr,
  input  logic [PID_W-1:0] pid_hi,
  input  logic [8:0]    wp_ctrl,
  input  logic [AW-1:0] wp_addr0,
  input  logic [AW-1:0] wp_addr1,
  input  logic          align_chk_en,
  input  logic          dbg_en,
  output logic [AW-1:0] eff_addr,
  output logic          align_abort,
  output logic          bp_hit,
  output logic [2:0]    entry_code,
  output logic          entry_code_we
);
  localparam int PID_LSB = AW - PID_W;
  localparam logic [2:0] ENTRY_DATA = 3'd2;
  localparam logic [AW-1:0] WORD_CARE = {{(AW-GRAN){1'b1}}, {GRAN{1'b0}}};

  function automatic logic mode_ok(input logic [1:0] m, input logic st);
    case (m)
      2'd1:    mode_ok = st;
      2'd2:    mode_ok = 1'b1;
      2'd3:    mode_ok = !st;
      default: mode_ok = 1'b0;
    endcase
  endfunction

  wire relocate = (pid_hi != '0) && (acc_addr[AW-1:PID_LSB] == '0);
  assign eff_addr = relocate ? {pid_hi, acc_addr[PID_LSB-1:0]} : acc_addr;

  wire mask_mode = wp_ctrl[8];
  logic [1:0][1:0]    cmp_mode;
  logic [1:0][AW-1:0] cmp_ref;
  logic [1:0]         cmp_hit;

  assign cmp_mode[0] = wp_ctrl[1:0];
  assign cmp_mode[1] = wp_ctrl[3:2];
  assign cmp_ref[0]  = wp_addr0;
  assign cmp_ref[1]  = wp_addr1;

  for (genvar i = 0; i < 2; i++) begin : g_cmp
    logic [AW-1:0] care;
    logic          live;
    if (i == 0) begin : g_first
      assign care = mask_mode ? ~wp_addr1 : WORD_CARE;
      assign live = 1'b1;
    end else begin : g_other
      assign care = WORD_CARE;
      assign live = !mask_mode;
    end
    assign cmp_hit[i] = live && mode_ok(cmp_mode[i], acc_store)
                        && ((eff_addr & care) == (cmp_ref[i] & care));
  end

  wire hit_now   = acc_valid && dbg_en && (cmp_hit != '0);
  wire abort_now = acc_valid && align_chk_en && (eff_addr[GRAN-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_hit        <= 1'b0;
      align_abort   <= 1'b0;
      entry_code_we <= 1'b0;
      entry_code    <= '0;
    end else begin
      bp_hit        <= hit_now;
      align_abort   <= abort_now;
      entry_code_we <= hit_now;
      if (hit_now) entry_code <= ENTRY_DATA;
    end
  end

  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    eff_addr[PID_LSB-1:0] == acc_addr[PID_LSB-1:0]); // R1
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    align_abort |-> ($past(align_chk_en) && $past(acc_addr[GRAN-1:0]) != '0)); // R2
  AST_HIT_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> $past(dbg_en)); // R3
  AST_HIT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> ($past(wp_ctrl[1:0]) != 2'd0 || (!$past(wp_ctrl[8]) && $past(wp_ctrl[3:2]) != 2'd0))); // R5
  AST_CODE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_code_we |-> (entry_code == ENTRY_DATA && bp_hit)); // R8
  AST_PULSE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_hit || align_abort) |-> $past(acc_valid)); // R9
endmodule

// File: tb/data_watch_unit_bench.sv
module data_watch_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_store = 0;
  logic [31:0] acc_addr = 0, wp_addr0 = 0, wp_addr1 = 0;
  logic [6:0]  pid_hi = 0;
  logic [8:0]  wp_ctrl = 0;
  logic        align_chk_en = 0, dbg_en = 0;
  logic [31:0] eff_addr;
  logic        align_abort, bp_hit, entry_code_we;
  logic [2:0]  entry_code;

  int n_chk = 0, n_bad = 0;

  data_watch_unit u_data_watch_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_addr(acc_addr), .pid_hi(pid_hi), .wp_ctrl(wp_ctrl),
    .wp_addr0(wp_addr0), .wp_addr1(wp_addr1), .align_chk_en(align_chk_en),
    .dbg_en(dbg_en), .eff_addr(eff_addr), .align_abort(align_abort),
    .bp_hit(bp_hit), .entry_code(entry_code), .entry_code_we(entry_code_we));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One access; checks the pulse in the following cycle and its end after that.
  task automatic access(input string tag, input logic st, input logic [31:0] a,
                        input logic exp_hit, input logic exp_abort);
    @(negedge clk);
    acc_valid = 1; acc_store = st; acc_addr = a;
    @(posedge clk); #1;
    acc_valid = 0;
    check({tag, " hit"}, {31'b0, bp_hit}, {31'b0, exp_hit});
    check({tag, " abort"}, {31'b0, align_abort}, {31'b0, exp_abort});
    if (exp_hit) begin
      check({tag, " R8 we"}, {31'b0, entry_code_we}, 32'd1);
      check({tag, " R8 code"}, {29'b0, entry_code}, 32'd2);
    end
    @(posedge clk); #1;
    check({tag, " R9 pulse ends"}, {30'b0, bp_hit, align_abort}, 32'd0);
  endtask

  task automatic t_reset;
    check("R9 reset hit", {31'b0, bp_hit}, 0);
    check("R9 reset abort", {31'b0, align_abort}, 0);
    check("R9 reset we", {31'b0, entry_code_we}, 0);
    check("R9 reset code", {29'b0, entry_code}, 0);
  endtask

  task automatic t_reloc;
    @(negedge clk);
    pid_hi = 7'h15; acc_addr = 32'h0000_1234; #1;
    check("R1 relocated", eff_addr, 32'h2A00_1234);
    acc_addr = 32'h0200_1234; #1;
    check("R1 upper set kept", eff_addr, 32'h0200_1234);
    pid_hi = 0; acc_addr = 32'h0000_1234; #1;
    check("R1 zero pid kept", eff_addr, 32'h0000_1234);
    // relocated address is compared
    pid_hi = 7'h01; dbg_en = 1; wp_ctrl = 9'h002; wp_addr0 = 32'h0200_0040;
    access("R1 compare relocated", 0, 32'h0000_0040, 1, 0);
    pid_hi = 0; wp_ctrl = 0; dbg_en = 0;
  endtask

  task automatic t_align;
    align_chk_en = 1;
    access("R2 misaligned", 0, 32'h0000_0102, 0, 1);
    access("R2 aligned", 1, 32'h0000_0104, 0, 0);
    align_chk_en = 0;
    access("R2 disabled", 0, 32'h0000_0103, 0, 0);
  endtask

  task automatic t_dbg_off;
    wp_ctrl = 9'h002; wp_addr0 = 32'h0000_8000; dbg_en = 0;
    access("R3 debug off", 0, 32'h0000_8000, 0, 0);
    dbg_en = 1;
    access("R3 debug on", 0, 32'h0000_8000, 1, 0);
  endtask

  task automatic t_modes;
    dbg_en = 1; wp_addr0 = 32'h0000_9000; wp_addr1 = 32'h0000_A000;
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        logic e;
        e = (m == 2) || (m == 1 && s == 1) || (m == 3 && s == 0);
        wp_ctrl = {7'b0, m[1:0]};
        access($sformatf("R5 cmp0 mode%0d st%0d", m, s), s[0], 32'h0000_9000, e, 0);
        wp_ctrl = {5'b0, m[1:0], 2'b0};
        access($sformatf("R4 cmp1 mode%0d st%0d", m, s), s[0], 32'h0000_A000, e, 0);
      end
    end
  endtask

  task automatic t_low_bits;
    wp_ctrl = 9'h002; wp_addr0 = 32'h1000_0003;
    access("R7 low bits ignored", 0, 32'h1000_0000, 1, 0);
    access("R7 next word", 0, 32'h1000_0004, 0, 0);
  endtask

  task automatic t_mask;
    wp_ctrl = 9'h10A; wp_addr0 = 32'h4000_0000; wp_addr1 = 32'h0000_0FFF;
    access("R6 masked hit", 1, 32'h4000_0ABC, 1, 0);
    access("R6 outside mask", 1, 32'h4000_1000, 0, 0);
    access("R6 cmp1 unused", 1, 32'h0000_0FFC, 0, 0);
  endtask

  task automatic t_both;
    wp_ctrl = 9'h00A; wp_addr0 = 32'h0000_C000; wp_addr1 = 32'h0000_C000;
    access("R10 double hit", 0, 32'h0000_C000, 1, 0);
  endtask

  task automatic t_no_strobe;
    wp_ctrl = 9'h002; wp_addr0 = 32'h0000_D000; align_chk_en = 1;
    @(negedge clk);
    acc_addr = 32'h0000_D001; acc_valid = 0;
    @(posedge clk); #1;
    check("R9 no strobe", {30'b0, bp_hit, align_abort}, 0);
    align_chk_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1;
    t_reloc;
    t_align;
    t_dbg_off;
    t_modes;
    t_low_bits;
    t_mask;
    t_both;
    t_no_strobe;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule